// File: doc/BRIEF.md
# Prime-Field Modular Arithmetic Unit

This unit computes wide-operand arithmetic modulo an odd modulus `m`. It supports modular addition, multiplication and division, plus two derived modes. Inversion runs the divider with a dividend of one. Reduction runs the adder with the second addend forced to zero. The operand width is the parameter `W`, which defaults to 163 bits.

Every operation works in ordinary (non-Montgomery) representation on one shared set of working registers. The unit is split into a sequencer and a datapath. The sequencer reads two status flags from the datapath and issues one micro-operation per cycle. Division never forms an inverse first. It runs a binary shift-and-subtract loop on four registers: a divisor copy, a modulus copy, and two residues. Multiplication scans `a` from its top bit down. Each doubling-and-add step is followed by two conditional subtractions of `m`.

A caller places an opcode and operands on the pins and raises `start` for one cycle while the unit is idle. The operands are captured on that edge. The caller then waits for the one-cycle `done` pulse. `start`, `done` and `err` are plain control pins with no back-pressure. A request that arrives while the unit is busy is dropped, so the caller must wait for `done` before issuing the next one.

Top module: `mod_arith_unit`

## Requirements
- R1: Opcode 3'b000 returns y = (a + b) mod m for a, b < m.
- R2: Opcode 3'b100 (reduce) returns y = a mod m for any a < 2m; the value on b has no effect on y.
- R3: Opcode 3'b001 or 3'b101 returns y = (a · b) mod m for a, b < m.
- R4: Opcode 3'b010 (divide) returns y < m with (y · b) mod m = a, for an odd prime m, a < m and 0 < b < m.
- R5: Opcode 3'b110 (invert) returns y with (y · b) mod m = 1; the value on a has no effect on y.
- R6: A divide or invert with b = 0 completes, with err = 1 and y = 0, on the second rising edge after the edge that accepts start.
- R7: An opcode whose low two bits are 2'b11 completes on the next rising edge with err = 1 and y = 0.
- R8: done is high for exactly one cycle per operation. y keeps its value until the next operation completes. err keeps its value until the next start is accepted, which clears it.
- R9: start is accepted only while idle, and operands are sampled only on the accepting edge. A start raised while busy neither changes the running result nor launches a further operation.
- R10: Counted from the edge that accepts start, done rises on the 3rd rising edge for add and reduce, and on edge 3·W+1 for multiply.
- R11: After reset, y = 0, done = 0 and err = 0.
- R12: Whenever done is high, y < m, where m is the modulus captured for that operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| opcode | input | 3 | Bits [1:0] select add/mul/div; bit 2 selects reduce (with add) or invert (with div) |
| a | input | W | First operand (dividend for divide) |
| b | input | W | Second operand (divisor for divide and invert) |
| m | input | W | Odd modulus; must be prime for divide and invert |
| y | output | W | Result, held until the next completion |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Division by zero or undefined opcode |

## Verification
The assertions assume that `m` is odd and that every operand is below `m`. They also assume that `m` is prime whenever a divide or invert is requested, because the loop's claim of a nonzero divisor copy rests on gcd(b, m) = 1. The single exception is the reduce input, which may reach up to 2m−1.

The stimulus table draws every modulus from three known primes: 251, 2^61−1 and 2^127−1. Each operand in the table was picked below the modulus used with it, and each reduce input was picked below twice that modulus. The only deliberate departures are b = 0 and the reserved opcode. For these, the requirements define the response, and no datapath invariant is involved.

// File: rtl/mau_pkg.sv
package mau_pkg;

  localparam logic [1:0] OP_ADD = 2'b00;
  localparam logic [1:0] OP_MUL = 2'b01;
  localparam logic [1:0] OP_DIV = 2'b10;

  // sequencer states double as datapath micro-operations
  typedef enum logic [3:0] {
    S_IDLE,
    S_LOAD,
    S_SUM,
    S_ASUB,
    S_MSTEP,
    S_MSUB1,
    S_MSUB2,
    S_DSTEP,
    S_FIN
  } mau_st_t;

endpackage

// File: rtl/mau_ctrl.sv
module mau_ctrl
  import mau_pkg::*;
#(
  parameter int W = 163
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] base_op,
  input  logic       a_one,
  input  logic       a_zero,
  output mau_st_t    uop,
  output logic       y_we,
  output logic       y_zero,
  output logic       done,
  output logic       err
);

  localparam int CW = $clog2(W + 1);

  mau_st_t       st;
  logic [CW-1:0] cnt;
  logic          bad;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      bad  <= 1'b0;
      done <= 1'b0;
      err  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          err <= 1'b0;
          case (base_op)
            OP_ADD: st <= S_SUM;
            OP_MUL: begin
              st  <= S_MSTEP;
              cnt <= CW'(W - 1);
            end
            OP_DIV: st <= S_DSTEP;
            default: begin
              bad <= 1'b1;
              st  <= S_FIN;
            end
          endcase
        end
        S_SUM:   st <= S_ASUB;
        S_ASUB:  st <= S_FIN;
        S_MSTEP: st <= S_MSUB1;
        S_MSUB1: st <= S_MSUB2;
        S_MSUB2: begin
          if (cnt == '0) st <= S_FIN;
          else begin
            cnt <= cnt - 1'b1;
            st  <= S_MSTEP;
          end
        end
        S_DSTEP: begin
          if (a_zero) begin
            bad <= 1'b1;
            st  <= S_FIN;
          end else if (a_one) begin
            st <= S_FIN;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          err  <= bad;
          bad  <= 1'b0;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    uop = st;
    if (st == S_IDLE) uop = start ? S_LOAD : S_IDLE;
    if (st == S_DSTEP && (a_one || a_zero)) uop = S_IDLE;
  end

  assign y_we   = (st == S_FIN);
  assign y_zero = bad;

  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

endmodule

// File: rtl/mau_dp.sv
module mau_dp
  import mau_pkg::*;
#(
  parameter int W = 163
) (
  input  logic         clk,
  input  logic         rst_n,
  input  mau_st_t      uop,
  input  logic [2:0]   opcode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  input  logic         y_we,
  input  logic         y_zero,
  output logic         a_one,
  output logic         a_zero,
  output logic [W-1:0] y
);

  localparam int XW = W + 2;

  logic [W-1:0]  ra, rb, rm;
  logic [XW-1:0] ru, rv, mx;

  assign mx     = {2'b00, rm};
  assign a_one  = (ra == W'(1));
  assign a_zero = (ra == '0);

  function automatic logic [XW-1:0] half_mod(input logic [XW-1:0] x, input logic [XW-1:0] md);
    logic [XW-1:0] s;
    s = x[0] ? x + md : x;
    return s >> 1;
  endfunction

  function automatic logic [XW-1:0] sub_mod(input logic [XW-1:0] x, input logic [XW-1:0] z,
                                            input logic [XW-1:0] md);
    return (x >= z) ? x - z : x + md - z;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ra <= '0;
      rb <= '0;
      rm <= '0;
      ru <= '0;
      rv <= '0;
      y  <= '0;
    end else begin
      case (uop)
        S_LOAD: begin
          rm <= m;
          case (opcode[1:0])
            OP_ADD: begin
              ru <= XW'(a);
              rv <= opcode[2] ? '0 : XW'(b);
            end
            OP_MUL: begin
              ra <= a;
              ru <= '0;
              rv <= XW'(b);
            end
            OP_DIV: begin
              ra <= b;
              rb <= m;
              ru <= opcode[2] ? XW'(1) : XW'(a);
              rv <= '0;
            end
            default: ;
          endcase
        end
        S_SUM: ru <= ru + rv;
        S_ASUB, S_MSUB1, S_MSUB2: if (ru >= mx) ru <= ru - mx;
        S_MSTEP: begin
          ru <= (ru << 1) + (ra[W-1] ? rv : '0);
          ra <= ra << 1;
        end
        S_DSTEP: begin
          if (!ra[0]) begin
            ra <= ra >> 1;
            ru <= half_mod(ru, mx);
          end else if (!rb[0]) begin
            rb <= rb >> 1;
            rv <= half_mod(rv, mx);
          end else if (ra >= rb) begin
            ra <= ra - rb;
            ru <= sub_mod(ru, rv, mx);
          end else begin
            rb <= rb - ra;
            rv <= sub_mod(rv, ru, mx);
          end
        end
        default: ;
      endcase
      if (y_we) y <= y_zero ? '0 : ru[W-1:0];
    end
  end

  // accumulator enters each multiply step already reduced
  a_r3_acc_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    (uop == S_MSTEP) |-> (ru < mx));

  // sequencer never steps the divider once the divisor copy reached zero
  a_r4_divisor_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (uop == S_DSTEP) |-> !a_zero);

  a_r12_result_reduced: assert property (@(posedge clk) disable iff (!rst_n)
    y_we |=> (y < rm));

endmodule

// File: rtl/mod_arith_unit.sv
module mod_arith_unit
  import mau_pkg::*;
#(
  parameter int W = 163
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [2:0]   opcode,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic [W-1:0] y,
  output logic         done,
  output logic         err
);

  mau_st_t uop;
  logic    a_one, a_zero, y_we, y_zero;

  mau_ctrl #(.W(W)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .base_op(opcode[1:0]),
    .a_one  (a_one),
    .a_zero (a_zero),
    .uop    (uop),
    .y_we   (y_we),
    .y_zero (y_zero),
    .done   (done),
    .err    (err)
  );

  mau_dp #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .uop    (uop),
    .opcode (opcode),
    .a      (a),
    .b      (b),
    .m      (m),
    .y_we   (y_we),
    .y_zero (y_zero),
    .a_one  (a_one),
    .a_zero (a_zero),
    .y      (y)
  );

  a_r8_y_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(y));

endmodule

// File: tb/tb_mod_arith_unit.sv
module tb_mod_arith_unit;

  localparam int W      = 163;
  localparam int CLK_NS = 10;
  localparam int NV     = 14;

  typedef logic [2*W+1:0] wide_t;

  localparam logic [W-1:0] P8   = 163'd251;
  localparam logic [W-1:0] P61  = 163'h1FFF_FFFF_FFFF_FFFF;
  localparam logic [W-1:0] P127 = 163'h7FFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;

  localparam logic [2:0] V_OP [NV] = '{
    3'b000, 3'b000, 3'b000, 3'b100, 3'b100,
    3'b001, 3'b001, 3'b101, 3'b001,
    3'b010, 3'b010, 3'b010, 3'b110, 3'b110};
  localparam logic [W-1:0] V_A [NV] = '{
    163'd200, P127 - 163'd1, 163'd5, 163'h2000_0000_0000_0004, 163'd100,
    163'd250, 163'h4000_0000_0000_0000_0000_0000_0000_0000, 163'd123456789, 163'd0,
    163'd1, 163'd12345, P61 - 163'd1, 163'd999, 163'd77};
  localparam logic [W-1:0] V_B [NV] = '{
    163'd100, 163'd1, 163'd6, 163'd777, 163'd9,
    163'd250, 163'd4, 163'd987654321, 163'd77,
    163'd2, 163'd67890, P61 - 163'd1, 163'd3, 163'd250};
  localparam logic [W-1:0] V_M [NV] = '{
    P8, P127, P61, P61, P8,
    P8, P127, P61, P8,
    P8, P127, P61, P127, P8};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [2:0]   opcode = '0;
  logic [W-1:0] a = '0, b = '0, m = '0;
  logic [W-1:0] y;
  logic         done, err;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  mod_arith_unit #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .a(a), .b(b), .m(m), .y(y), .done(done), .err(err));

  always #(CLK_NS / 2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic ok, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] op, input logic [W-1:0] ta, input logic [W-1:0] tb,
                        input logic [W-1:0] tm, output int lat);
    @(negedge clk);
    opcode = op; a = ta; b = tb; m = tm; start = 1'b1;
    @(negedge clk);
    start = 1'b0; a = '1; b = '1; m = '1;
    lat = 0;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'b000:          return "R1";
      3'b100:          return "R2";
      3'b001, 3'b101:  return "R3";
      3'b010:          return "R4";
      default:         return "R5";
    endcase
  endfunction

  initial begin
    int lat;
    logic [W-1:0] exp_v, held;
    wide_t prod;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset values
    chk("R11 y", y == '0, y, '0);
    chk("R11 done", done == 1'b0, W'(done), '0);
    chk("R11 err", err == 1'b0, W'(err), '0);

    for (int i = 0; i < NV; i++) begin
      run_op(V_OP[i], V_A[i], V_B[i], V_M[i], lat);
      chk("done seen", lat < 5000, W'(lat), W'(5000));
      if (V_OP[i][1:0] == 2'b10) begin
        exp_v = V_OP[i][2] ? W'(1) : V_A[i];
        prod  = (wide_t'(y) * wide_t'(V_B[i])) % wide_t'(V_M[i]);
        chk(tag_of(V_OP[i]), prod == wide_t'(exp_v), W'(prod), exp_v);
      end else begin
        if (V_OP[i] == 3'b100) prod = wide_t'(V_A[i]) % wide_t'(V_M[i]);
        else if (V_OP[i][1:0] == 2'b00) prod = (wide_t'(V_A[i]) + wide_t'(V_B[i])) % wide_t'(V_M[i]);
        else prod = (wide_t'(V_A[i]) * wide_t'(V_B[i])) % wide_t'(V_M[i]);
        chk(tag_of(V_OP[i]), y == W'(prod), y, W'(prod));
        // R10: fixed latency
        chk("R10 latency", lat == ((V_OP[i][1:0] == 2'b00) ? 3 : 3 * W + 1), W'(lat),
            W'((V_OP[i][1:0] == 2'b00) ? 3 : 3 * W + 1));
      end
      chk("R12 y<m", y < V_M[i], y, V_M[i]);
      chk("R6 no err", err == 1'b0, W'(err), '0);
      @(negedge clk);
      // R8: single-cycle pulse
      chk("R8 done pulse", done == 1'b0, W'(done), '0);
    end

    // R8: y holds after completion
    held = y;
    repeat (5) @(negedge clk);
    chk("R8 y held", y == held, y, held);

    // R6: division and inversion by zero
    run_op(3'b010, 163'd5, 163'd0, P8, lat);
    chk("R6 div0 err", err == 1'b1, W'(err), W'(1));
    chk("R6 div0 y", y == '0, y, '0);
    chk("R6 div0 latency", lat == 2, W'(lat), W'(2));
    repeat (3) @(negedge clk);
    chk("R8 err held", err == 1'b1, W'(err), W'(1));
    run_op(3'b110, 163'd5, 163'd0, P61, lat);
    chk("R6 inv0 err", err == 1'b1 && y == '0, W'(err), W'(1));

    // R8: err cleared by next accepted start
    run_op(3'b000, 163'd1, 163'd2, P8, lat);
    chk("R8 err cleared", err == 1'b0, W'(err), '0);
    chk("R1 after err", y == W'(3), y, W'(3));

    // R7: reserved opcode
    run_op(3'b011, 163'd4, 163'd4, P8, lat);
    chk("R7 err", err == 1'b1, W'(err), W'(1));
    chk("R7 y", y == '0, y, '0);
    chk("R7 latency", lat == 1, W'(lat), W'(1));

    // R9: start while busy is ignored
    @(negedge clk);
    opcode = 3'b001; a = 163'd250; b = 163'd250; m = P8; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    opcode = 3'b000; a = 163'd1; b = 163'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 21;
    while (!done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    chk("R9 result", y == W'(1), y, W'(1));
    chk("R9 latency", lat == 3 * W + 1, W'(lat), W'(3 * W + 1));
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (done) chk("R9 extra op", 1'b0, W'(done), '0);
    end
    chk("R9 y kept", y == W'(1), y, W'(1));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule